// File: doc/BRIEF.md
# Seven-Level Priority Interrupt Controller

This block gathers the interrupt request lines of a printer-style controller's peripherals and presents the processor with one 3-bit priority level. Each source line is edge sensitive. A rising edge latches a per-source pending bit. The pending bits are mapped onto seven fixed levels, from level 1 (lowest) to level 7 (highest). Some levels are fed by more than one source. The output is the highest level that has a pending bit and is not masked. It reads 0 when no such level exists.

Level 7 carries the non-maskable request. Levels 1 to 6 each have a mask bit. A masked pending bit stays latched and visible, and it is presented again once the mask is lifted. The processor retires requests in one of two ways. It can acknowledge a level, which clears every source on that level. It can also write ones into the per-source status vector. Because the status vector is per source, software can tell which source caused a request on a shared level.

Top module: `irqc_top`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `pend_o` is all zero and `irq_lvl_o` is 0.
- R2: A 0-to-1 transition on `src_i[i]`, seen between two clock edges, sets `pend_o[i]` at the next edge. A line that stays high sets the bit only once. A line already high when reset ends does not set the bit.
- R3: Sources map to levels by bit index: bit 0 to level 1; bits 1, 2 and 3 (host interface and data-extension group) to level 2; bit 4 (scan) to level 3; bit 5 (beam detect) and bit 6 (timer 1) to level 4; bit 7 (serial option) to level 5; bit 8 (video buffer) to level 6; bit 9 to level 7.
- R4: `irq_lvl_o` is the highest level that has a pending, unmasked source, and it changes in the same cycle as `pend_o`. It is 0 when no such level exists.
- R5: `mask_i[k-1]` set to 1 removes level k (k = 1..6) from `irq_lvl_o`. The pending bits of that level are kept and are presented again when the mask bit returns to 0.
- R6: Level 7 (bit 9) ignores every mask bit. When bit 9 is pending, `irq_lvl_o` is 7.
- R7: `ack_i` high at an edge, with `ack_lvl_i` = k in 1..7, clears the pending bits of all sources mapped to level k, whatever the mask. Other levels are untouched. When k = 0, nothing is cleared.
- R8: `clr_we_i` high at an edge clears each pending bit whose `clr_bits_i` bit is 1. Bits written as 0 keep their state.
- R9: When a rising edge on a source and a clear of that same source (by acknowledge or by write) land on one edge, the bit ends up set.
- R10: On the shared level 4, either source alone raises level 4, and `pend_o` shows which source or sources are pending. One acknowledge of level 4 clears both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_i | input | 10 | Per-source request lines, edge sensitive |
| mask_i | input | 6 | Mask bits; bit k-1 masks level k |
| ack_i | input | 1 | Processor acknowledge strobe |
| ack_lvl_i | input | 3 | Level being acknowledged |
| clr_we_i | input | 1 | Write strobe for write-one-to-clear |
| clr_bits_i | input | 10 | Per-source clear bits |
| irq_lvl_o | output | 3 | Highest pending unmasked level, 0 if none |
| pend_o | output | 10 | Per-source pending status |

## Verification
The assertions assume that `ack_lvl_i`, `clr_bits_i` and `mask_i` are meaningful only while their strobe or the output they affect is being observed. They also assume that the source lines are synchronous to `clk`, so that a sampled edge is a real edge. The bench changes every input on the falling clock edge only, raises each source for one cycle or holds it for a known span, and separates vectors with a full write-one-to-clear. In this way, no request left over from one case reaches the next. Same-edge collisions between a new request and a clear are produced on purpose and only in the directed case that targets them.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    // Level numbering
    localparam int LVL_W   = 3;
    localparam int NUM_LVL = 7;
    localparam int NUM_MSK = NUM_LVL - 1;

    // Source index layout (bit positions of src_i / pend_o)
    localparam int HOST_SRCS   = 3;
    localparam int IDX_TMR2    = 0;
    localparam int IDX_HOST_LO = IDX_TMR2 + 1;
    localparam int IDX_HOST_HI = IDX_HOST_LO + HOST_SRCS - 1;
    localparam int IDX_SCAN    = IDX_HOST_HI + 1;
    localparam int IDX_BEAM    = IDX_SCAN + 1;
    localparam int IDX_TMR1    = IDX_BEAM + 1;
    localparam int IDX_SERIAL  = IDX_TMR1 + 1;
    localparam int IDX_VIDEO   = IDX_SERIAL + 1;
    localparam int IDX_NMI     = IDX_VIDEO + 1;
    localparam int NUM_SRC     = IDX_NMI + 1;

    typedef enum logic [LVL_W-1:0] {
        LVL_NONE   = 3'd0,
        LVL_TMR2   = 3'd1,
        LVL_HOST   = 3'd2,
        LVL_SCAN   = 3'd3,
        LVL_BEAM   = 3'd4,
        LVL_SERIAL = 3'd5,
        LVL_VIDEO  = 3'd6,
        LVL_NMI    = 3'd7
    } irq_lvl_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [NUM_LVL-1:0] lvl_vec_t;
    typedef logic [NUM_MSK-1:0] msk_vec_t;

    typedef struct packed {
        logic             req;
        logic [LVL_W-1:0] lvl;
    } ack_t;

    typedef struct packed {
        logic     we;
        src_vec_t bits;
    } clr_t;

    // Level of one source index
    function automatic logic [LVL_W-1:0] src_level(input int idx);
        logic [LVL_W-1:0] l;
        if (idx == IDX_TMR2)                             l = LVL_TMR2;
        else if (idx >= IDX_HOST_LO && idx <= IDX_HOST_HI) l = LVL_HOST;
        else if (idx == IDX_SCAN)                        l = LVL_SCAN;
        else if (idx == IDX_BEAM || idx == IDX_TMR1)     l = LVL_BEAM;
        else if (idx == IDX_SERIAL)                      l = LVL_SERIAL;
        else if (idx == IDX_VIDEO)                       l = LVL_VIDEO;
        else if (idx == IDX_NMI)                         l = LVL_NMI;
        else                                             l = LVL_NONE;
        return l;
    endfunction

    // All sources that feed one level; level 0 maps to nothing
    function automatic src_vec_t lvl_sources(input logic [LVL_W-1:0] l);
        src_vec_t m;
        for (int i = 0; i < NUM_SRC; i++) begin
            m[i] = (l != LVL_NONE) && (src_level(i) == l);
        end
        return m;
    endfunction

    // Highest set level in a level vector (bit k-1 stands for level k)
    function automatic logic [LVL_W-1:0] top_level(input lvl_vec_t v);
        logic [LVL_W-1:0] r;
        r = LVL_NONE;
        for (int k = 1; k <= NUM_LVL; k++) begin
            if (v[k-1]) r = LVL_W'(k);
        end
        return r;
    endfunction

endpackage

// File: rtl/irqc_edge_det.sv
module irqc_edge_det
    import irqc_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] line_i,
    output logic [N-1:0] rise_o
);

    logic [N-1:0] prev_q;

    // Per-line edge capture; prev resets high so a line held through reset
    // produces no edge.
    for (genvar g = 0; g < N; g++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) prev_q[g] <= 1'b1;
            else     prev_q[g] <= line_i[g];
        end
        assign rise_o[g] = line_i[g] & ~prev_q[g];
    end

endmodule

// File: rtl/irqc_pend_reg.sv
module irqc_pend_reg
    import irqc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t rise_i,
    input  ack_t     ack_i,
    input  clr_t     clr_i,
    output src_vec_t pend_o
);

    src_vec_t pend_q;
    src_vec_t ack_clr;
    src_vec_t wr_clr;
    src_vec_t pend_d;

    always_comb begin
        ack_clr = ack_i.req ? lvl_sources(ack_i.lvl) : '0;
        wr_clr  = clr_i.we  ? clr_i.bits : '0;
        // a fresh edge wins over any clear landing on the same edge
        pend_d  = (pend_q & ~(ack_clr | wr_clr)) | rise_i;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    // R2: every captured edge is pending one cycle later
    a_r2_edge_sets: assert property (@(posedge clk) disable iff (rst)
        (rise_i != '0) |=> ((pend_q & $past(rise_i)) == $past(rise_i)));

    // R2: with no edge and no clear the pending vector holds
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        (rise_i == '0 && !ack_i.req && !clr_i.we) |=> $stable(pend_q));

    // R7: acknowledged level is empty afterwards unless re-raised
    a_r7_ack_clears: assert property (@(posedge clk) disable iff (rst)
        (ack_i.req && ack_i.lvl != LVL_NONE) |=>
        ((pend_q & lvl_sources($past(ack_i.lvl)) & ~$past(rise_i)) == '0));

    // R8: written ones are cleared unless re-raised
    a_r8_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        clr_i.we |=> ((pend_q & $past(clr_i.bits) & ~$past(rise_i)) == '0));

endmodule

// File: rtl/irqc_lvl_enc.sv
module irqc_lvl_enc
    import irqc_pkg::*;
(
    input  src_vec_t         pend_i,
    input  msk_vec_t         mask_i,
    output logic [LVL_W-1:0] lvl_o
);

    lvl_vec_t act;
    lvl_vec_t eff;

    // OR-reduce the sources of every level
    for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
        assign act[k] = |(pend_i & lvl_sources(LVL_W'(k + 1)));
    end

    // top level has no mask bit
    assign eff   = act & {1'b1, ~mask_i};
    assign lvl_o = top_level(eff);

endmodule

// File: rtl/irqc_top.sv
module irqc_top
    import irqc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  src_i,
    input  logic [NUM_MSK-1:0]  mask_i,
    input  logic                ack_i,
    input  logic [LVL_W-1:0]    ack_lvl_i,
    input  logic                clr_we_i,
    input  logic [NUM_SRC-1:0]  clr_bits_i,
    output logic [LVL_W-1:0]    irq_lvl_o,
    output logic [NUM_SRC-1:0]  pend_o
);

    src_vec_t rise;
    ack_t     ack_s;
    clr_t     clr_s;

    assign ack_s = '{req: ack_i, lvl: ack_lvl_i};
    assign clr_s = '{we: clr_we_i, bits: clr_bits_i};

    irqc_edge_det #(.N(NUM_SRC)) edge_i (
        .clk    (clk),
        .rst    (rst),
        .line_i (src_i),
        .rise_o (rise)
    );

    irqc_pend_reg pend_i (
        .clk    (clk),
        .rst    (rst),
        .rise_i (rise),
        .ack_i  (ack_s),
        .clr_i  (clr_s),
        .pend_o (pend_o)
    );

    irqc_lvl_enc enc_i (
        .pend_i (pend_o),
        .mask_i (mask_i),
        .lvl_o  (irq_lvl_o)
    );

    // R6: non-maskable source always dominates
    a_r6_nmi_wins: assert property (@(posedge clk) disable iff (rst)
        pend_o[IDX_NMI] |-> (irq_lvl_o == LVL_NMI));

    // R5: a presented maskable level is never masked
    a_r5_masked_hidden: assert property (@(posedge clk) disable iff (rst)
        (irq_lvl_o != LVL_NONE && irq_lvl_o != LVL_NMI) |->
        !mask_i[irq_lvl_o - 3'd1]);

    // R4: nothing pending means level 0
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (rst)
        (pend_o == '0) |-> (irq_lvl_o == LVL_NONE));

    // R4: a presented level always has a pending source behind it
    a_r4_level_backed: assert property (@(posedge clk) disable iff (rst)
        (irq_lvl_o != LVL_NONE) |-> ((pend_o & lvl_sources(irq_lvl_o)) != '0));

endmodule

// File: tb/irqc_top_tb_top.sv
module irqc_top_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic [9:0] src;
    logic [5:0] mask;
    logic       ack;
    logic [2:0] ack_lvl;
    logic       clr_we;
    logic [9:0] clr_bits;
    logic [2:0] lvl;
    logic [9:0] pend;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    irqc_top dut_i (
        .clk        (clk),
        .rst        (rst),
        .src_i      (src),
        .mask_i     (mask),
        .ack_i      (ack),
        .ack_lvl_i  (ack_lvl),
        .clr_we_i   (clr_we),
        .clr_bits_i (clr_bits),
        .irq_lvl_o  (lvl),
        .pend_o     (pend)
    );

    typedef struct packed {
        logic [9:0] src;
        logic [5:0] mask;
        logic [2:0] lvl;
    } vec_t;

    // pulse pattern, mask, expected level (expected pending = pattern)
    localparam vec_t VECS [10] = '{
        '{src: 10'h001, mask: 6'h00, lvl: 3'd1},  // R3 timer 2
        '{src: 10'h004, mask: 6'h00, lvl: 3'd2},  // R3 host group
        '{src: 10'h011, mask: 6'h00, lvl: 3'd3},  // R4 scan over timer 2
        '{src: 10'h020, mask: 6'h00, lvl: 3'd4},  // R10 beam alone
        '{src: 10'h040, mask: 6'h00, lvl: 3'd4},  // R10 timer 1 alone
        '{src: 10'h082, mask: 6'h00, lvl: 3'd5},  // R4 serial over host
        '{src: 10'h100, mask: 6'h3F, lvl: 3'd0},  // R5 video masked
        '{src: 10'h300, mask: 6'h3F, lvl: 3'd7},  // R6 nmi ignores mask
        '{src: 10'h101, mask: 6'h20, lvl: 3'd1},  // R5 level 6 masked only
        '{src: 10'h000, mask: 6'h00, lvl: 3'd0}   // R4 nothing pending
    };

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic clear_all();
        clr_we = 1'b1; clr_bits = 10'h3FF;
        step();
        clr_we = 1'b0; clr_bits = '0;
    endtask

    task automatic pulse(input logic [9:0] p);
        src = p;
        step();
        src = '0;
    endtask

    task automatic do_ack(input logic [2:0] l);
        ack = 1'b1; ack_lvl = l;
        step();
        ack = 1'b0; ack_lvl = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; src = '0; mask = '0; ack = 1'b0; ack_lvl = '0;
        clr_we = 1'b0; clr_bits = '0;
        repeat (3) step();
        // R1 during reset
        check("R1 pend in reset", pend, 0);
        check("R1 lvl in reset", lvl, 0);
        rst = 1'b0;
        step();
        check("R1 pend after reset", pend, 0);
        check("R1 lvl after reset", lvl, 0);

        // vector table walk
        foreach (VECS[i]) begin
            clear_all();
            mask = VECS[i].mask;
            pulse(VECS[i].src);
            check($sformatf("R3 vec%0d pend", i), pend, VECS[i].src);
            check($sformatf("R4 vec%0d lvl", i), lvl, VECS[i].lvl);
        end
        clear_all();
        mask = '0;

        // R5: unmask restores a kept pending level
        mask = 6'h20;
        pulse(10'h100);
        check("R5 masked lvl", lvl, 0);
        check("R5 masked pend kept", pend, 10'h100);
        mask = 6'h00;
        #1;
        check("R5 unmasked lvl", lvl, 6);
        clear_all();

        // R2: held line sets once; after clearing it does not re-set
        src = 10'h010;
        step();
        check("R2 held sets", pend, 10'h010);
        clr_we = 1'b1; clr_bits = 10'h010;
        step();
        clr_we = 1'b0; clr_bits = '0;
        step(); step();
        check("R2 held no re-set", pend, 0);
        src = '0;
        step();
        pulse(10'h010);
        check("R2 new edge sets", pend, 10'h010);
        clear_all();

        // R2: line high across reset gives no edge
        src = 10'h008;
        rst = 1'b1;
        step();
        rst = 1'b0;
        step(); step();
        check("R2 high through reset", pend, 0);
        src = '0;
        step();

        // R10 + R7: both level-4 sources, ack 4 clears both only
        pulse(10'h061);
        check("R10 both shown", pend, 10'h061);
        check("R10 lvl 4", lvl, 4);
        do_ack(3'd0);
        check("R7 ack level 0 no effect", pend, 10'h061);
        do_ack(3'd4);
        check("R7 ack 4 clears shared", pend, 10'h001);
        check("R7 lvl after ack", lvl, 1);

        // R7: ack of a masked level still clears
        mask = 6'h01;
        do_ack(3'd1);
        check("R7 masked ack", pend, 0);
        mask = '0;

        // R8: zeros in clear word are ignored
        pulse(10'h101);
        clr_we = 1'b1; clr_bits = 10'h001;
        step();
        clr_we = 1'b0; clr_bits = '0;
        check("R8 partial clear", pend, 10'h100);
        check("R8 lvl", lvl, 6);
        clear_all();

        // R9: edge and clear on the same edge -> set
        pulse(10'h001);
        step();
        src = 10'h001; clr_we = 1'b1; clr_bits = 10'h001;
        step();
        src = '0; clr_we = 1'b0; clr_bits = '0;
        check("R9 edge beats w1c", pend, 10'h001);
        step();
        src = 10'h001; ack = 1'b1; ack_lvl = 3'd1;
        step();
        src = '0; ack = 1'b0; ack_lvl = '0;
        check("R9 edge beats ack", pend, 10'h001);
        clear_all();

        // R6: nmi with everything else pending and all masks set
        mask = 6'h3F;
        pulse(10'h3FF);
        check("R6 nmi top", lvl, 7);
        do_ack(3'd7);
        check("R6 after nmi ack", lvl, 0);
        check("R7 ack 7 only nmi", pend, 10'h1FF);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule